// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter with Vectoring

This block chooses which of five interrupt sources is handed to the CPU sequencer. The sources are two external request flags, two timer overflow flags and one serial source. The serial source is the OR of a receive flag and a transmit flag. The CPU marks the final state of every machine cycle with a one-clock `cycleEnd` strobe, and the arbiter polls the flags on that strobe. A request that is accepted at one cycle end becomes a call at the next cycle end. The call is a one-clock `callReq` pulse, together with a fixed vector address and a one-hot acknowledge naming the winning source.

Each source has an enable bit and a priority bit, and a global enable gates all of them. The arbiter keeps one in-service bit for each of the two priority levels. A request is refused while an equal or higher level is in service. It is also refused when the CPU reports that the current machine cycle is not the last one of the instruction, or that the instruction is a return-from-interrupt or a write to the enable or priority registers. When a return-from-interrupt completes, the arbiter releases the innermost active level.

The arbiter does not own the flags. It returns clear strobes for the two external and two timer flags. The serial flags are left to software.

Top module: `irqArbTop`

## Requirements
- R1: Polling happens only on a clock edge where `cycleEnd` is 1. A request accepted at one such edge produces `callReq` at the next `cycleEnd` edge. `callReq` is high for exactly one clock. At a `cycleEnd` edge where a call is issued, no new request is accepted.
- R2: A pending source whose priority bit is 1 (high level) wins over every pending source whose priority bit is 0, whatever their polling order.
- R3: Within one level, the lowest source index wins. The index order is 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial. The same index order applies to `srcEn`, `srcHigh` and `ack`.
- R4: The vector issued with `callReq` equals 0x0003 + 8 × index: 0x0003, 0x000B, 0x0013, 0x001B, 0x0023. The vector keeps its value until the next call.
- R5: A source takes part in polling only when its `srcEn` bit and `globalEn` are both 1. A disabled source is skipped, and the next enabled source in order wins.
- R6: A high-level request is refused while `inService[1]` is set. A low-level request is refused while either in-service bit is set. A high-level request is accepted while only the low level is in service, and its call sets `inService[1]`.
- R7: A request is accepted only at a cycle end where `lastCycle` is 1.
- R8: A request is refused at a cycle end where `retiExec` or `ctrlWrite` is 1. The same request is accepted at the last cycle of a later instruction.
- R9: `ack` is one-hot while `callReq` is high and zero otherwise. `flagClr[i]` pulses together with `ack[i]` for the sources 0 to 3. The serial source never produces a clear strobe.
- R10: The serial source requests whenever `serRxFlag` or `serTxFlag` is 1.
- R11: A cycle end with both `retiExec` and `lastCycle` at 1 clears `inService[1]` if it is set, and clears `inService[0]` otherwise. If a call is issued at the same edge, the release acts on the state held before the edge, and then the new level's bit is set.
- R12: After reset, `callReq`, `vector`, `ack`, `flagClr` and `inService` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleEnd | input | 1 | One-clock strobe marking the final state of a machine cycle |
| extFlag | input | 2 | External request flags 0 and 1 |
| tmrFlag | input | 2 | Timer overflow flags 0 and 1 |
| serRxFlag | input | 1 | Serial receive flag |
| serTxFlag | input | 1 | Serial transmit flag |
| globalEn | input | 1 | Master interrupt enable |
| srcEn | input | 5 | Per-source enable, in polling index order |
| srcHigh | input | 5 | Per-source priority, 1 = high level |
| lastCycle | input | 1 | Current machine cycle is the last one of the instruction |
| retiExec | input | 1 | Current instruction is a return-from-interrupt |
| ctrlWrite | input | 1 | Current instruction writes the enable or priority registers |
| callReq | output | 1 | One-clock request to the sequencer to perform the vectored call |
| vector | output | 16 | Entry address of the winning source |
| ack | output | 5 | One-hot acknowledge of the winning source |
| flagClr | output | 4 | Hardware clear strobes for the external and timer flags |
| inService | output | 2 | In-service bits, bit 1 = high level, bit 0 = low level |

## Verification
The delicate coincidence is a call issued at the same cycle end as a return-from-interrupt release. Both act on `inService` in one register update. The bench provokes this with the low level in service: it latches a high-level request, then ends the next machine cycle with `retiExec` and `lastCycle` both raised. It judges the result by requiring `callReq` with vector 0x000B and `inService` equal to 2'b10. That value shows the release cleared the old low-level bit before the new high-level bit was set. A second overlap is also exercised: a pending request reaching its call edge while the CPU status would otherwise allow a fresh acceptance. At that edge, no second call may follow.

// File: rtl/irqArbPkg.sv
package irqArbPkg;
  localparam int NUM_SRC = 5;
  localparam int IDX_W   = $clog2(NUM_SRC);

  typedef struct packed {
    logic pollEn;     // latch the current winner as pending
    logic fireEn;     // issue the call for the pending source
    logic releaseEn;  // return-from-interrupt completes
  } arbStrobeT;

  typedef struct packed {
    logic candValid;   // some enabled source is requesting
    logic candBlocked; // winner is held off by the in-service levels
  } arbStatusT;
endpackage

// File: rtl/irqArbControl.sv
module irqArbControl
  import irqArbPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cycleEnd,
  input  logic      lastCycle,
  input  logic      retiExec,
  input  logic      ctrlWrite,
  input  arbStatusT status,
  output arbStrobeT strobes
);
  logic pendValid;
  logic pollOk;

  // Blocking rules evaluated at the polling edge.
  always_comb begin
    pollOk = cycleEnd && !pendValid && lastCycle && !retiExec && !ctrlWrite &&
             status.candValid && !status.candBlocked;
    strobes.pollEn    = pollOk;
    strobes.fireEn    = cycleEnd && pendValid;
    strobes.releaseEn = cycleEnd && retiExec && lastCycle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
    end else if (cycleEnd) begin
      pendValid <= pollOk;
    end
  end

  // R8: an accepted request never coincides with a control-register write
  assert_no_accept_on_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pollEn |-> !ctrlWrite && !retiExec);

  // R1: a call follows only a prior acceptance
  assert_fire_after_accept_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendValid) |-> !strobes.fireEn);
endmodule

// File: rtl/irqArbDatapath.sv
module irqArbDatapath
  import irqArbPkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqFlags,
  input  logic               globalEn,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] srcHigh,
  input  arbStrobeT          strobes,
  output arbStatusT          status,
  output logic               callReq,
  output logic [VEC_W-1:0]   vector,
  output logic [NUM_SRC-1:0] ack,
  output logic [NUM_SRC-2:0] flagClr,
  output logic [1:0]         inService
);
  localparam int LVL_HI = 1;
  localparam int LVL_LO = 0;

  logic [NUM_SRC-1:0] active;
  logic               hiFound, loFound;
  logic [IDX_W-1:0]   hiIdx, loIdx;
  logic [IDX_W-1:0]   candIdx;
  logic               candLvl;
  logic [IDX_W-1:0]   pendIdx;
  logic               pendLvl;
  logic [1:0]         inSvcNext;
  logic [NUM_SRC-1:0] ackNext;

  assign active = reqFlags & srcEn & {NUM_SRC{globalEn}};

  // Fixed polling order: the lowest index wins within each level.
  always_comb begin
    hiFound = 1'b0;
    loFound = 1'b0;
    hiIdx   = '0;
    loIdx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active[i] && srcHigh[i]) begin
        hiFound = 1'b1;
        hiIdx   = IDX_W'(i);
      end
      if (active[i] && !srcHigh[i]) begin
        loFound = 1'b1;
        loIdx   = IDX_W'(i);
      end
    end
    candIdx            = hiFound ? hiIdx : loIdx;
    candLvl            = hiFound;
    status.candValid   = hiFound || loFound;
    status.candBlocked = inService[LVL_HI] || (!candLvl && inService[LVL_LO]);
  end

  // Release acts on the old state first, then the new call's level is set.
  always_comb begin
    inSvcNext = inService;
    if (strobes.releaseEn) begin
      if (inSvcNext[LVL_HI]) inSvcNext[LVL_HI] = 1'b0;
      else                   inSvcNext[LVL_LO] = 1'b0;
    end
    if (strobes.fireEn) inSvcNext[pendLvl] = 1'b1;
    ackNext = strobes.fireEn ? (NUM_SRC'(1) << pendIdx) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendIdx   <= '0;
      pendLvl   <= 1'b0;
      callReq   <= 1'b0;
      vector    <= '0;
      ack       <= '0;
      flagClr   <= '0;
      inService <= '0;
    end else begin
      if (strobes.pollEn) begin
        pendIdx <= candIdx;
        pendLvl <= candLvl;
      end
      callReq   <= strobes.fireEn;
      ack       <= ackNext;
      flagClr   <= ackNext[NUM_SRC-2:0];
      inService <= inSvcNext;
      if (strobes.fireEn) begin
        vector <= VEC_W'(VEC_BASE) + VEC_W'(pendIdx) * VEC_W'(VEC_STEP);
      end
    end
  end

  // R9: acknowledge is one-hot exactly while the call is raised
  assert_ack_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> $countones(ack) == 1);
  assert_ack_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !callReq |-> ack == '0 && flagClr == '0);

  // R1: the call is a single-clock pulse
  assert_call_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    callReq |=> !callReq);

  // R6: a call always leaves its level marked in service
  assert_insvc_on_call_R6: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> inService != 2'b00);

  // R4: vectors sit on the 8-byte grid offset by 3
  assert_vec_grid_R4: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> vector[2:0] == 3'd3);
endmodule

// File: rtl/irqArbTop.sv
module irqArbTop
  import irqArbPkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cycleEnd,
  input  logic [1:0]         extFlag,
  input  logic [1:0]         tmrFlag,
  input  logic               serRxFlag,
  input  logic               serTxFlag,
  input  logic               globalEn,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] srcHigh,
  input  logic               lastCycle,
  input  logic               retiExec,
  input  logic               ctrlWrite,
  output logic               callReq,
  output logic [VEC_W-1:0]   vector,
  output logic [NUM_SRC-1:0] ack,
  output logic [NUM_SRC-2:0] flagClr,
  output logic [1:0]         inService
);
  arbStrobeT          strobes;
  arbStatusT          status;
  logic [NUM_SRC-1:0] reqFlags;

  // Polling index order: ext0, tmr0, ext1, tmr1, serial (rx OR tx).
  assign reqFlags = {serRxFlag | serTxFlag, tmrFlag[1], extFlag[1], tmrFlag[0], extFlag[0]};

  irqArbControl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cycleEnd  (cycleEnd),
    .lastCycle (lastCycle),
    .retiExec  (retiExec),
    .ctrlWrite (ctrlWrite),
    .status    (status),
    .strobes   (strobes)
  );

  irqArbDatapath #(
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .reqFlags  (reqFlags),
    .globalEn  (globalEn),
    .srcEn     (srcEn),
    .srcHigh   (srcHigh),
    .strobes   (strobes),
    .status    (status),
    .callReq   (callReq),
    .vector    (vector),
    .ack       (ack),
    .flagClr   (flagClr),
    .inService (inService)
  );

  // R1: calls appear only right after a machine-cycle end
  assert_call_at_cycle_end_R1: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> $past(cycleEnd));
endmodule

// File: tb/sim_irqArbTop.sv
module sim_irqArbTop;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cycleEnd;
  logic [1:0]  extFlag, tmrFlag;
  logic        serRxFlag, serTxFlag;
  logic        globalEn;
  logic [4:0]  srcEn, srcHigh;
  logic        lastCycle, retiExec, ctrlWrite;
  logic        callReq;
  logic [15:0] vector;
  logic [4:0]  ack;
  logic [3:0]  flagClr;
  logic [1:0]  inService;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irqArbTop u0 (
    .clk(clk), .rstN(rstN), .cycleEnd(cycleEnd), .extFlag(extFlag), .tmrFlag(tmrFlag),
    .serRxFlag(serRxFlag), .serTxFlag(serTxFlag), .globalEn(globalEn), .srcEn(srcEn),
    .srcHigh(srcHigh), .lastCycle(lastCycle), .retiExec(retiExec), .ctrlWrite(ctrlWrite),
    .callReq(callReq), .vector(vector), .ack(ack), .flagClr(flagClr), .inService(inService)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // One machine cycle of two clocks; the second edge carries cycleEnd.
  task automatic mc(input logic l, input logic r, input logic w);
    @(negedge clk);
    lastCycle = l; retiExec = r; ctrlWrite = w; cycleEnd = 1'b0;
    @(negedge clk);
    cycleEnd = 1'b1;
    @(negedge clk);
    cycleEnd = 1'b0;
  endtask

  task automatic setFlag(input int idx, input logic v);
    case (idx)
      0: extFlag[0] = v;
      1: tmrFlag[0] = v;
      2: extFlag[1] = v;
      3: tmrFlag[1] = v;
      default: serTxFlag = v;
    endcase
  endtask

  task automatic expectCall(input string req, input int idx, input logic [1:0] svc);
    chk(req, "callReq", {31'd0, callReq}, 32'd1);
    chk("R4", "vector", {16'd0, vector}, 32'(3 + 8 * idx));
    chk("R9", "ack", {27'd0, ack}, 32'(1) << idx);
    chk("R9", "flagClr", {28'd0, flagClr}, (idx < 4) ? (32'(1) << idx) : 32'd0);
    chk("R6", "inService", {30'd0, inService}, {30'd0, svc});
  endtask

  task automatic expectNone(input string req);
    chk(req, "no callReq", {31'd0, callReq}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R12", "callReq", {31'd0, callReq}, 0);
    chk("R12", "vector", {16'd0, vector}, 0);
    chk("R12", "ack", {27'd0, ack}, 0);
    chk("R12", "flagClr", {28'd0, flagClr}, 0);
    chk("R12", "inService", {30'd0, inService}, 0);
  endtask

  // R3: all five low-level sources pending, served in polling order
  task automatic t_order;
    for (int k = 0; k < 5; k++) setFlag(k, 1'b1);
    for (int k = 0; k < 5; k++) begin
      mc(1, 0, 0);
      expectNone("R1");
      mc(0, 0, 0);
      expectCall("R3", k, 2'b01);
      setFlag(k, 1'b0);
      mc(1, 1, 0);
      expectNone("R1");
      chk("R11", "inService after return", {30'd0, inService}, 0);
    end
  endtask

  // R10: receive flag alone raises the serial request
  task automatic t_serialRx;
    serRxFlag = 1'b1;
    mc(1, 0, 0); mc(0, 0, 0);
    expectCall("R10", 4, 2'b01);
    serRxFlag = 1'b0;
    mc(1, 1, 0);
  endtask

  // R2: high level beats lower polling index
  task automatic t_priority;
    srcHigh = 5'b01000;
    extFlag[0] = 1'b1; tmrFlag[1] = 1'b1;
    mc(1, 0, 0); mc(0, 0, 0);
    expectCall("R2", 3, 2'b10);
    tmrFlag[1] = 1'b0;
    mc(1, 1, 0);
    chk("R11", "inService", {30'd0, inService}, 0);
    mc(1, 0, 0); mc(0, 0, 0);
    expectCall("R2", 0, 2'b01);
    extFlag[0] = 1'b0;
    mc(1, 1, 0);
    srcHigh = 5'b00000;
  endtask

  // R5: global and per-source enables
  task automatic t_enable;
    extFlag[0] = 1'b1;
    globalEn = 1'b0;
    mc(1, 0, 0); mc(1, 0, 0);
    expectNone("R5");
    globalEn = 1'b1; srcEn = 5'b11110;
    mc(1, 0, 0); mc(1, 0, 0);
    expectNone("R5");
    tmrFlag[0] = 1'b1;
    mc(1, 0, 0); mc(0, 0, 0);
    expectCall("R5", 1, 2'b01);
    tmrFlag[0] = 1'b0; extFlag[0] = 1'b0; srcEn = 5'b11111;
    mc(1, 1, 0);
  endtask

  // R7: only the last machine cycle of an instruction may accept
  task automatic t_lastCycle;
    extFlag[1] = 1'b1;
    mc(0, 0, 0); mc(0, 0, 0);
    expectNone("R7");
    mc(1, 0, 0); mc(0, 0, 0);
    expectCall("R7", 2, 2'b01);
    extFlag[1] = 1'b0;
    mc(1, 1, 0);
  endtask

  // R8: return-from-interrupt and control writes defer the response
  task automatic t_blocking;
    extFlag[1] = 1'b1;
    mc(1, 1, 0); mc(0, 0, 0);
    expectNone("R8");
    mc(1, 0, 1); mc(0, 0, 0);
    expectNone("R8");
    mc(1, 0, 0); mc(0, 0, 0);
    expectCall("R8", 2, 2'b01);
    extFlag[1] = 1'b0;
    mc(1, 1, 0);
  endtask

  // R6: nesting rules across the two levels
  task automatic t_nesting;
    srcHigh = 5'b01010;
    extFlag[0] = 1'b1;
    mc(1, 0, 0); mc(0, 0, 0);
    expectCall("R6", 0, 2'b01);
    extFlag[0] = 1'b0;
    extFlag[1] = 1'b1;
    mc(1, 0, 0); mc(1, 0, 0);
    expectNone("R6");
    tmrFlag[0] = 1'b1;
    mc(1, 0, 0); mc(0, 0, 0);
    expectCall("R6", 1, 2'b11);
    tmrFlag[0] = 1'b0;
    tmrFlag[1] = 1'b1;
    mc(1, 0, 0); mc(1, 0, 0);
    expectNone("R6");
    mc(1, 1, 0);
    chk("R11", "high released first", {30'd0, inService}, 32'b01);
    mc(1, 0, 0); mc(0, 0, 0);
    expectCall("R6", 3, 2'b11);
    tmrFlag[1] = 1'b0; extFlag[1] = 1'b0;
    mc(1, 1, 0);
    chk("R11", "inService", {30'd0, inService}, 32'b01);
    mc(1, 1, 0);
    chk("R11", "inService", {30'd0, inService}, 32'b00);
    srcHigh = 5'b00000;
  endtask

  // R11: release and call share one cycle end
  task automatic t_coincide;
    srcHigh = 5'b00010;
    extFlag[0] = 1'b1;
    mc(1, 0, 0); mc(0, 0, 0);
    expectCall("R11", 0, 2'b01);
    extFlag[0] = 1'b0;
    tmrFlag[0] = 1'b1;
    mc(1, 0, 0);
    mc(1, 1, 0);
    expectCall("R11", 1, 2'b10);
    tmrFlag[0] = 1'b0;
    mc(1, 0, 0);
    expectNone("R1");
    mc(1, 1, 0);
    chk("R11", "inService", {30'd0, inService}, 0);
    srcHigh = 5'b00000;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; cycleEnd = 1'b0; extFlag = '0; tmrFlag = '0;
    serRxFlag = 1'b0; serTxFlag = 1'b0; globalEn = 1'b1;
    srcEn = 5'b11111; srcHigh = 5'b00000;
    lastCycle = 1'b0; retiExec = 1'b0; ctrlWrite = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_serialRx();
    t_priority();
    t_enable();
    t_lastCycle();
    t_blocking();
    t_nesting();
    t_coincide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule